// File: doc/BRIEF.md
# RGMII Receive Byte Recombiner

This block turns the double-data-rate receive signals of a reduced gigabit media interface into a single-rate byte stream. An input DDR capture stage outside the block samples the 4-bit receive data bus and the single receive control line on both edges of the receive clock. It hands over four values each cycle: the data nibble and control bit captured on the rising edge, and the nibble and control bit captured on the falling edge.

The block joins the two nibbles into one byte. It decodes the control pair into a data-valid flag and a receive-error flag. The control line's falling-edge level is not the error itself. It is data-valid exclusive-ORed with error, so the error is recovered by comparing the two control samples. Byte, valid and error pass through one shared register, so they leave together on the receive clock. The receive clock runs continuously at 125, 25 or 2.5 MHz, and the block has no rate-specific logic. A frame parser or MAC receive path downstream takes this stream.

Top module: `rgmii_rx_recombiner`

## Requirements
- R1: Bits 3:0 of `rx_byte` carry the data nibble captured on the rising edge (`rxd_rise`).
- R2: Bits 7:4 of `rx_byte` carry the data nibble captured on the falling edge (`rxd_fall`).
- R3: `rx_dv` equals the rising-edge control sample `rxctl_rise`.
- R4: `rx_err` equals `rxctl_rise` XOR `rxctl_fall`.
- R5: Control sampled high on both edges gives `rx_dv`=1 and `rx_err`=0 (valid byte, no error).
- R6: Control high on the rising edge and low on the falling edge gives `rx_dv`=1 and `rx_err`=1 (valid byte carrying an error).
- R7: Control low on both edges gives `rx_dv`=0 and `rx_err`=0 (no frame).
- R8: Control low on the rising edge and high on the falling edge gives `rx_dv`=0 and `rx_err`=1. The byte is still passed through unchanged, so that false-carrier and carrier-extension codes can be recognised downstream.
- R9: All three outputs are registered together. Inputs present at one rising clock edge appear on `rx_byte`, `rx_dv` and `rx_err` right after that edge, with no skew between the outputs, and back-to-back inputs give back-to-back outputs.
- R10: A synchronous active-high `rst` forces `rx_byte`, `rx_dv` and `rx_err` to zero after the next rising edge, whatever the inputs are at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_rise | input | 4 | Data nibble captured on the rising edge |
| rxd_fall | input | 4 | Data nibble captured on the falling edge |
| rxctl_rise | input | 1 | Control line captured on the rising edge |
| rxctl_fall | input | 1 | Control line captured on the falling edge |
| rx_byte | output | 8 | Recombined receive byte |
| rx_dv | output | 1 | Receive data valid |
| rx_err | output | 1 | Receive error |

## Verification
Two things can fall in the same cycle: a valid byte and an error flag (R6), or reset and live input traffic (R10). The bench drives a valid byte with the falling control sample pulled low. It then checks that the byte value, `rx_dv`=1 and `rx_err`=1 all appear in the same output cycle, with nothing shifted by a cycle. It also raises `rst` while an erroring valid byte is on the inputs, and checks that all outputs read zero after that edge rather than the byte.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;

  // Four-way classification of the control pair captured across one receive clock.
  typedef enum logic [1:0] {
    LINK_IDLE     = 2'b00,  // low / low
    LINK_CARRIER  = 2'b01,  // low / high : error without valid data
    LINK_DATA_ERR = 2'b10,  // high / low : valid data carrying an error
    LINK_DATA     = 2'b11   // high / high
  } link_state_e;

  typedef struct packed {
    logic dv;
    logic err;
  } rx_flags_t;

endpackage

// File: rtl/rgmii_nibble_join.sv
module rgmii_nibble_join #(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W  = 2 * NIBBLE_W
) (
  input  logic [NIBBLE_W-1:0] lo_nib,
  input  logic [NIBBLE_W-1:0] hi_nib,
  output logic [BYTE_W-1:0]   byte_o
);

  // Place each lane bit by bit: rising sample low, falling sample high.
  for (genvar i = 0; i < NIBBLE_W; i++) begin : g_lane
    assign byte_o[i]            = lo_nib[i];
    assign byte_o[NIBBLE_W + i] = hi_nib[i];
  end

endmodule

// File: rtl/rgmii_ctl_decode.sv
module rgmii_ctl_decode
  import rgmii_rx_pkg::*;
(
  input  logic      ctl_r,
  input  logic      ctl_f,
  output rx_flags_t flags
);

  link_state_e state;

  always_comb begin
    state = link_state_e'({ctl_r, ctl_f});
  end

  always_comb begin
    unique case (state)
      LINK_DATA:     flags = '{dv: 1'b1, err: 1'b0};
      LINK_DATA_ERR: flags = '{dv: 1'b1, err: 1'b1};
      LINK_CARRIER:  flags = '{dv: 1'b0, err: 1'b1};
      default:       flags = '{dv: 1'b0, err: 1'b0};
    endcase
  end

endmodule

// File: rtl/rgmii_rx_outreg.sv
module rgmii_rx_outreg
  import rgmii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_d,
  input  rx_flags_t         flags_d,
  output logic [BYTE_W-1:0] byte_q,
  output rx_flags_t         flags_q
);

  // One shared register stage so byte and flags stay cycle-aligned.
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= '0;
      flags_q <= '0;
    end else begin
      byte_q  <= byte_d;
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/rgmii_rx_recombiner.sv
module rgmii_rx_recombiner
  import rgmii_rx_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W  = 2 * NIBBLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIBBLE_W-1:0] rxd_rise,
  input  logic [NIBBLE_W-1:0] rxd_fall,
  input  logic              rxctl_rise,
  input  logic              rxctl_fall,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_dv,
  output logic              rx_err
);

  logic [BYTE_W-1:0] joined;
  rx_flags_t         flags_c;
  rx_flags_t         flags_r;

  rgmii_nibble_join #(.NIBBLE_W(NIBBLE_W)) u_join (
    .lo_nib (rxd_rise),
    .hi_nib (rxd_fall),
    .byte_o (joined)
  );

  rgmii_ctl_decode u_dec (
    .ctl_r (rxctl_rise),
    .ctl_f (rxctl_fall),
    .flags (flags_c)
  );

  rgmii_rx_outreg #(.BYTE_W(BYTE_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .byte_d  (joined),
    .flags_d (flags_c),
    .byte_q  (rx_byte),
    .flags_q (flags_r)
  );

  assign rx_dv  = flags_r.dv;
  assign rx_err = flags_r.err;

endmodule

// File: rtl/rgmii_rx_recombiner_chk.sv
module rgmii_rx_recombiner_chk #(
  parameter int NIBBLE_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NIBBLE_W-1:0]   rxd_rise,
  input logic [NIBBLE_W-1:0]   rxd_fall,
  input logic                  rxctl_rise,
  input logic                  rxctl_fall,
  input logic [2*NIBBLE_W-1:0] rx_byte,
  input logic                  rx_dv,
  input logic                  rx_err
);

  p_lo_nibble_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_byte[NIBBLE_W-1:0] == $past(rxd_rise));

  p_hi_nibble_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_byte[2*NIBBLE_W-1:NIBBLE_W] == $past(rxd_fall));

  p_dv_rise_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_dv == $past(rxctl_rise));

  p_err_xor_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_err == ($past(rxctl_rise) != $past(rxctl_fall)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rxctl_rise) && !$past(rxctl_fall)) |-> (!rx_dv && !rx_err));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_byte == '0 && !rx_dv && !rx_err));

endmodule

bind rgmii_rx_recombiner rgmii_rx_recombiner_chk #(.NIBBLE_W(NIBBLE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rxd_rise   (rxd_rise),
  .rxd_fall   (rxd_fall),
  .rxctl_rise (rxctl_rise),
  .rxctl_fall (rxctl_fall),
  .rx_byte    (rx_byte),
  .rx_dv      (rx_dv),
  .rx_err     (rx_err)
);

// File: tb/sim_rgmii_rx_recombiner.sv
module sim_rgmii_rx_recombiner;

  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rxd_rise = '0;
  logic [3:0] rxd_fall = '0;
  logic       rxctl_rise = 1'b0;
  logic       rxctl_fall = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_dv;
  logic       rx_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgmii_rx_recombiner u0 (
    .clk(clk), .rst(rst),
    .rxd_rise(rxd_rise), .rxd_fall(rxd_fall),
    .rxctl_rise(rxctl_rise), .rxctl_fall(rxctl_fall),
    .rx_byte(rx_byte), .rx_dv(rx_dv), .rx_err(rx_err)
  );

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (byte,dv,err)", req, act, exp);
    end
  endtask

  // Drive at a falling edge; a rising edge captures; sample at the next falling edge.
  task automatic apply(logic [3:0] r, logic [3:0] f, logic cr, logic cf);
    rxd_rise = r; rxd_fall = f; rxctl_rise = cr; rxctl_fall = cf;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    apply(4'hF, 4'hF, 1'b1, 1'b0);
    apply(4'hF, 4'hF, 1'b1, 1'b0);
    check("R10 reset state", {rx_byte, rx_dv, rx_err}, 10'h000);
    rst = 1'b0;
  endtask

  task automatic t_nibble_order();
    apply(4'h5, 4'hA, 1'b1, 1'b1);
    check("R1 low nibble", {6'h0, rx_byte[3:0]}, {6'h0, 4'h5});
    check("R2 high nibble", {6'h0, rx_byte[7:4]}, {6'h0, 4'hA});
    apply(4'hC, 4'h3, 1'b1, 1'b1);
    check("R1 R2 byte 3C", {rx_byte, rx_dv, rx_err}, {8'h3C, 1'b1, 1'b0});
  endtask

  task automatic t_ctl_table();
    apply(4'h1, 4'h2, 1'b1, 1'b1);
    check("R5 valid no error", {rx_byte, rx_dv, rx_err}, {8'h21, 1'b1, 1'b0});
    apply(4'h7, 4'h9, 1'b1, 1'b0);
    check("R6 valid with error", {rx_byte, rx_dv, rx_err}, {8'h97, 1'b1, 1'b1});
    apply(4'h6, 4'hB, 1'b0, 1'b0);
    check("R7 idle", {2'b0, rx_dv, rx_err}, 4'b0000);
    apply(4'hE, 4'h0, 1'b0, 1'b1);
    check("R8 carrier event with byte", {rx_byte, rx_dv, rx_err}, {8'h0E, 1'b0, 1'b1});
    apply(4'hF, 4'hF, 1'b0, 1'b1);
    check("R8 extension byte FF", {rx_byte, rx_dv, rx_err}, {8'hFF, 1'b0, 1'b1});
  endtask

  task automatic t_rule_sweep();
    for (int k = 0; k < 64; k++) begin
      logic [3:0] r = 4'(k * 5 + 3);
      logic [3:0] f = 4'(k * 11 + 7);
      logic cr = k[0];
      logic cf = k[1] ^ k[3];
      apply(r, f, cr, cf);
      check("R3 dv follows rising control", {9'h0, rx_dv}, {9'h0, cr});
      check("R4 err is xor of control pair", {9'h0, rx_err}, {9'h0, cr ^ cf});
      check("R9 aligned stream", {rx_byte, rx_dv, rx_err}, {f, r, cr, cr ^ cf});
    end
  endtask

  task automatic t_latency();
    // Present one byte, then change inputs; outputs must show the first byte only for one cycle.
    apply(4'h4, 4'hD, 1'b1, 1'b0);
    check("R9 same-cycle error with byte", {rx_byte, rx_dv, rx_err}, {8'hD4, 1'b1, 1'b1});
    apply(4'h0, 4'h0, 1'b0, 1'b0);
    check("R9 next cycle updates", {rx_byte, rx_dv, rx_err}, {8'h00, 1'b0, 1'b0});
  endtask

  task automatic t_reset_midstream();
    apply(4'h8, 4'h8, 1'b1, 1'b1);
    rst = 1'b1;
    apply(4'h9, 4'hE, 1'b1, 1'b0);
    check("R10 reset wins over traffic", {rx_byte, rx_dv, rx_err}, 10'h000);
    rst = 1'b0;
    apply(4'h2, 4'hB, 1'b1, 1'b0);
    check("R10 recovery after reset", {rx_byte, rx_dv, rx_err}, {8'hB2, 1'b1, 1'b1});
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_nibble_order();
    t_ctl_table();
    t_rule_sweep();
    t_latency();
    t_reset_midstream();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule